// File: doc/BRIEF.md
# SHA-512 Message Schedule Sigma1 Completion Stage

This block finishes one step of SHA-512 message expansion, producing four new 64-bit schedule words per operation. It receives two 256-bit operands. The first carries four partial sums, one per output lane, that an earlier stage has already prepared. The upper half of the second carries the two most recent schedule words. For each lane the block adds the lower-case sigma1 of a source word to that lane's partial sum.

The two lower lanes take their sigma1 sources from the history operand. The two upper lanes take theirs from the words that the lower lanes have just produced. This makes a serial chain of two sigma1-plus-add steps inside one operation, rather than four independent lanes. Operations enter and leave through valid/ready handshakes, and the result comes from a register.

The parameter `SPLIT_STAGES` selects the depth:
- 0 computes the whole chain in front of a single output register.
- 1 registers the two lower results together with the two upper partial sums, and then finishes the upper lanes in a second stage.

The handshake behaves the same in both cases. Only the latency changes.

Top module: `sched_sig1_finish`

## Requirements
- R1: Output lane 0 (bits 63:0) equals lane 0 of `part_i` plus sig1 of lane 2 of `hist_i` (bits 191:128). sig1(x) = rotr(x,19) XOR rotr(x,61) XOR (x logical-right-shifted by 6).
- R2: Output lane 1 (bits 127:64) equals lane 1 of `part_i` plus sig1 of lane 3 of `hist_i` (bits 255:192).
- R3: Output lane 2 (bits 191:128) equals lane 2 of `part_i` plus sig1 of the new output lane 0 of the same operation.
- R4: Output lane 3 (bits 255:192) equals lane 3 of `part_i` plus sig1 of the new output lane 1 of the same operation.
- R5: Every addition is modulo 2^64, and the carry out of bit 63 is discarded.
- R6: Lanes 0 and 1 of `hist_i` (bits 127:0) have no effect on the result.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `words_o` stays unchanged.
- R8: Reset, which is synchronous and active high, clears `out_valid`. Immediately after reset, `in_ready` is high.
- R9: With `out_ready` held high, an operation accepted at a clock edge shows `out_valid` high exactly 1 + `SPLIT_STAGES` cycles later.
- R10: While `out_ready` is high, `in_ready` is high, so back-to-back operations are accepted one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair is presented |
| in_ready | output | 1 | Block can accept an operand pair this cycle |
| part_i | input | 256 | Four partial sums, lane i at bits 64i+63:64i |
| hist_i | input | 256 | History words; only lanes 2 and 3 are used |
| out_valid | output | 1 | Result word set is available |
| out_ready | input | 1 | Consumer takes the result this cycle |
| words_o | output | 256 | Four new schedule words, lane i at bits 64i+63:64i |

## Verification
An operation accepted at a rising edge with the consumer ready must show its result 1 + `SPLIT_STAGES` cycles later. A dedicated latency test counts cycles from the accepting edge to the first cycle in which `out_valid` is seen, and compares the count with that figure.

All other results are matched in order by a scoreboard at the cycle in which a transfer is seen. The outputs are sampled midway through the low clock phase, after `out_ready` has settled. When a stall is seen in one cycle, the bench requires the same valid data in the next cycle.

// File: rtl/sched_pkg.sv
package sched_pkg;

    localparam int unsigned QW      = 64;
    localparam int unsigned NLANE   = 4;
    localparam int unsigned VEC_W   = QW * NLANE;
    localparam int unsigned ROT_LO  = 19;
    localparam int unsigned ROT_HI  = 61;
    localparam int unsigned SHR_AMT = 6;

    typedef logic [QW-1:0]    qword_t;
    typedef logic [VEC_W-1:0] vec_t;

    // Carried between the two halves of the chain when it is split.
    typedef struct packed {
        qword_t part3;
        qword_t part2;
        qword_t new1;
        qword_t new0;
    } mid_t;

    function automatic qword_t rot_right(input qword_t x, input int unsigned n);
        return (x >> n) | (x << (QW - n));
    endfunction

    function automatic qword_t small_sig1(input qword_t x);
        return rot_right(x, ROT_LO) ^ rot_right(x, ROT_HI) ^ (x >> SHR_AMT);
    endfunction

    function automatic qword_t lane_of(input vec_t v, input int unsigned i);
        return v[i*QW +: QW];
    endfunction

endpackage

// File: rtl/sched_sig1_add.sv
module sched_sig1_add
    import sched_pkg::*;
(
    input  qword_t addend,
    input  qword_t src,
    output qword_t sum
);
    qword_t mixed;

    always_comb begin
        mixed = small_sig1(src);
        sum   = addend + mixed;   // wraps modulo 2^64
    end
endmodule

// File: rtl/sched_hold_reg.sv
module sched_hold_reg #(
    parameter int unsigned W = 256
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);
    logic         full_q;
    logic [W-1:0] data_q;

    assign in_ready  = !full_q || out_ready;
    assign out_valid = full_q;
    assign out_data  = data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q <= 1'b0;
        end else if (in_valid && in_ready) begin
            full_q <= 1'b1;
        end else if (out_ready) begin
            full_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (in_valid && in_ready) begin
            data_q <= in_data;
        end
    end

    // R7: a stalled result keeps its valid and its data
    p_hold_stable_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R8: the register is empty in the first cycle after reset
    p_empty_after_reset_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !out_valid);

    // R9: an accepted item is visible at the next edge
    p_accept_visible_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> out_valid);
endmodule

// File: rtl/sched_sig1_finish.sv
module sched_sig1_finish
    import sched_pkg::*;
#(
    parameter int unsigned SPLIT_STAGES = 0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [VEC_W-1:0]      part_i,
    input  logic [VEC_W-1:0]      hist_i,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [VEC_W-1:0]      words_o
);
    localparam int unsigned HALF = NLANE / 2;

    // Lanes 0 and 1 of the history operand are not part of the function.
    logic   unused_hist_lo;
    qword_t new_lo [HALF];

    assign unused_hist_lo = ^hist_i[HALF*QW-1:0];

    // First link of the chain: lower lanes from the history words.
    for (genvar g = 0; g < HALF; g++) begin : g_lo
        sched_sig1_add u_add (
            .addend (lane_of(part_i, g)),
            .src    (lane_of(hist_i, g + HALF)),
            .sum    (new_lo[g])
        );
    end

    if (SPLIT_STAGES == 0) begin : g_single
        qword_t new_hi [HALF];
        vec_t   packed_out;

        for (genvar g = 0; g < HALF; g++) begin : g_hi
            sched_sig1_add u_add (
                .addend (lane_of(part_i, g + HALF)),
                .src    (new_lo[g]),
                .sum    (new_hi[g])
            );
        end

        assign packed_out = {new_hi[1], new_hi[0], new_lo[1], new_lo[0]};

        sched_hold_reg #(.W(VEC_W)) u_out (
            .clk       (clk),
            .rst       (rst),
            .in_valid  (in_valid),
            .in_ready  (in_ready),
            .in_data   (packed_out),
            .out_valid (out_valid),
            .out_ready (out_ready),
            .out_data  (words_o)
        );
    end else begin : g_split
        mid_t   mid_d, mid_q;
        logic   mid_valid, mid_ready;
        qword_t new_hi [HALF];
        vec_t   packed_out;

        assign mid_d = '{part3: lane_of(part_i, 3), part2: lane_of(part_i, 2),
                         new1:  new_lo[1],          new0:  new_lo[0]};

        sched_hold_reg #(.W(VEC_W)) u_mid (
            .clk       (clk),
            .rst       (rst),
            .in_valid  (in_valid),
            .in_ready  (in_ready),
            .in_data   (mid_d),
            .out_valid (mid_valid),
            .out_ready (mid_ready),
            .out_data  (mid_q)
        );

        // Second link of the chain, from the registered lower results.
        sched_sig1_add u_add2 (
            .addend (mid_q.part2),
            .src    (mid_q.new0),
            .sum    (new_hi[0])
        );
        sched_sig1_add u_add3 (
            .addend (mid_q.part3),
            .src    (mid_q.new1),
            .sum    (new_hi[1])
        );

        assign packed_out = {new_hi[1], new_hi[0], mid_q.new1, mid_q.new0};

        sched_hold_reg #(.W(VEC_W)) u_out (
            .clk       (clk),
            .rst       (rst),
            .in_valid  (mid_valid),
            .in_ready  (mid_ready),
            .in_data   (packed_out),
            .out_valid (out_valid),
            .out_ready (out_ready),
            .out_data  (words_o)
        );

        // R7: the middle stage never drops an item while the tail is stalled
        p_mid_hold_r7: assert property (@(posedge clk) disable iff (rst)
            (mid_valid && !mid_ready) |=> mid_valid);
    end

    // R10: a ready consumer keeps the input side open
    p_ready_flow_r10: assert property (@(posedge clk) disable iff (rst)
        out_ready |-> in_ready);

    // R8: an empty block always accepts
    p_empty_accepts_r8: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> in_ready);
endmodule

// File: tb/sched_sig1_finish_tb_top.sv
module sched_sig1_finish_tb_top;
    localparam int unsigned SPLIT = 1;
    localparam int unsigned LAT   = SPLIT + 1;
    localparam int unsigned WD    = 20000;

    typedef struct {
        logic [255:0] exp;
        string        note;
    } item_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [255:0] part_i = '0;
    logic [255:0] hist_i = '0;
    logic         out_valid;
    logic         out_ready = 1'b1;
    logic [255:0] words_o;

    int    errors = 0;
    int    checks = 0;
    item_t sb_q[$];
    bit    mon_en = 1'b0;
    int    rdy_mode = 0;
    logic [15:0] lfsr = 16'hACE1;
    string lane_req [4] = '{"R1", "R2", "R3", "R4"};

    always #4 clk = ~clk;   // 125 MHz

    sched_sig1_finish #(.SPLIT_STAGES(SPLIT)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .part_i    (part_i),
        .hist_i    (hist_i),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .words_o   (words_o)
    );

    function automatic logic [63:0] m_sig1(input logic [63:0] x);
        return {x[18:0], x[63:19]} ^ {x[60:0], x[63:61]} ^ (x >> 6);
    endfunction

    function automatic logic [255:0] model(input logic [255:0] p, input logic [255:0] h);
        logic [63:0] w0, w1, w2, w3;
        w0 = p[63:0]    + m_sig1(h[191:128]);
        w1 = p[127:64]  + m_sig1(h[255:192]);
        w2 = p[191:128] + m_sig1(w0);
        w3 = p[255:192] + m_sig1(w1);
        return {w3, w2, w1, w0};
    endfunction

    function automatic logic [63:0] rnd64();
        return {$urandom, $urandom};
    endfunction

    task automatic report(input bit ok, input string req, input logic [255:0] act,
                          input logic [255:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver: present one pair, push the expectation, hold until taken.
    task automatic send(input logic [255:0] p, input logic [255:0] h,
                        input string note, output int tries);
        bit took;
        tries = 0;
        @(negedge clk);
        in_valid = 1'b1;
        part_i   = p;
        hist_i   = h;
        forever begin
            #1;
            took = in_ready;
            tries++;
            if (took) sb_q.push_back('{exp: model(p, h), note: note});
            @(posedge clk);
            if (took) break;
            @(negedge clk);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic drain();
        idle();
        while (sb_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // Consumer ready pattern
    always @(negedge clk) begin
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        out_ready = (rdy_mode == 0) ? 1'b1 : (lfsr[0] | lfsr[3]);
    end

    // Monitor: stall hold (R7) and in-order scoreboard (R1..R4)
    initial begin
        bit           prev_stall = 1'b0;
        logic [255:0] prev_data  = '0;
        item_t        it;
        forever begin
            @(negedge clk);
            #2;
            if (mon_en) begin
                if (prev_stall)
                    report(out_valid && (words_o == prev_data), "R7 stalled hold",
                           words_o, prev_data);
                if (out_valid && out_ready) begin
                    if (sb_q.size() == 0) begin
                        report(1'b0, "R1 unexpected output", words_o, '0);
                    end else begin
                        it = sb_q.pop_front();
                        for (int i = 0; i < 4; i++) begin
                            checks++;
                            if (words_o[i*64 +: 64] !== it.exp[i*64 +: 64]) begin
                                errors++;
                                $display("FAIL %s lane %0d (%s): actual=%h expected=%h",
                                         lane_req[i], i, it.note,
                                         words_o[i*64 +: 64], it.exp[i*64 +: 64]);
                            end
                        end
                    end
                end
                prev_stall = out_valid && !out_ready;
                prev_data  = words_o;
            end
        end
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (WD) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog (R9 progress): actual=hung expected=done");
        finish_run();
    end

    initial begin
        int tries;
        int cnt;
        logic [255:0] p, h, h2;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #2;
        // R8: reset state
        report(out_valid == 1'b0, "R8 out_valid after reset", {255'd0, out_valid}, '0);
        report(in_ready == 1'b1, "R8 in_ready after reset", {255'd0, in_ready}, 256'd1);
        mon_en = 1'b1;

        // Directed: zero operands, then single-lane patterns
        send('0, '0, "zeros", tries);
        send({64'd4, 64'd3, 64'd2, 64'd1}, {64'h1, 64'h80000, 128'd0}, "small values", tries);
        send('0, {64'h8000000000000000, 64'h0000000000000001, 128'd0}, "edge bits", tries);

        // R5: wrap in lane 0 and lane 1 and the chained lanes
        send({4{64'hFFFFFFFFFFFFFFFF}}, {64'hFFFFFFFFFFFFFFFF, 64'h0123456789ABCDEF, 128'd0},
             "R5 modulo wrap", tries);

        // R6: lower history lanes changed, same result expected
        p  = {rnd64(), rnd64(), rnd64(), rnd64()};
        h  = {rnd64(), rnd64(), 128'd0};
        h2 = {h[255:128], rnd64(), rnd64()};
        send(p, h,  "R6 lower hist zero", tries);
        send(p, h2, "R6 lower hist random", tries);
        drain();

        // R9: latency with consumer ready
        rdy_mode = 0;
        send({rnd64(), rnd64(), rnd64(), rnd64()}, {rnd64(), rnd64(), rnd64(), rnd64()},
             "R9 latency item", tries);
        cnt = 0;
        @(negedge clk);
        in_valid = 1'b0;
        forever begin
            #3;
            cnt++;
            if (out_valid || cnt > 10) break;
            @(negedge clk);
        end
        report(cnt == LAT, "R9 latency cycles", 256'(cnt), 256'(LAT));
        drain();

        // R10: back-to-back acceptance with consumer ready
        for (int k = 0; k < 8; k++) begin
            send({rnd64(), rnd64(), rnd64(), rnd64()}, {rnd64(), rnd64(), rnd64(), rnd64()},
                 "R10 streaming", tries);
            report(tries == 1, "R10 accepted first cycle", 256'(tries), 256'd1);
        end
        drain();

        // R7 plus R1..R4 under random back-pressure
        rdy_mode = 1;
        for (int k = 0; k < 40; k++)
            send({rnd64(), rnd64(), rnd64(), rnd64()}, {rnd64(), rnd64(), rnd64(), rnd64()},
                 "R7 random back-pressure", tries);
        rdy_mode = 0;
        drain();

        finish_run();
    end
endmodule